// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with Result Registers

This block performs integer multiplication and division over several clock cycles and keeps the outcome in two dedicated result registers, called HI and LO here. A CPU issues an operation with a one-cycle start strobe, an operation code and two operands. The unit then works one bit per clock until it writes both result registers.

A multiply leaves the upper half of the double-width product in HI and the lower half in LO. A divide leaves the quotient in LO and the remainder in HI. The result registers are read only through a dedicated read port. While an operation is in flight, a read gets a stall indication instead of data. The CPU holds its read request until the stall drops. The CPU handles all pipeline hazards itself, using the busy and stall outputs.

Top module: `mdu_hilo_unit`

## Requirements
- R1: Operation code 2'b00 is a signed multiply. The two's-complement product is 2W bits wide: its upper W bits go to HI and its lower W bits go to LO.
- R2: Operation code 2'b01 is an unsigned multiply, with the same split of the 2W-bit product: upper half to HI, lower half to LO.
- R3: Operation code 2'b10 is a signed divide with a non-zero divisor. LO receives the quotient truncated toward zero and HI receives the remainder, which carries the sign of the dividend. The most negative dividend divided by -1 yields the low W bits of the true quotient.
- R4: Operation code 2'b11 is an unsigned divide with a non-zero divisor. LO receives the quotient and HI receives the remainder.
- R5: A divide by zero, signed or unsigned, completes without any trap. It writes all ones to LO and writes the dividend, unchanged, to HI.
- R6: busy_o rises in the cycle after a start is accepted while idle. It stays high for exactly W+1 cycles, and HI and LO hold their new values once it falls.
- R7: A start strobe raised while busy_o is high is ignored. The results are those of the operation already in flight.
- R8: With rd_req_i high while busy_o is high, stall_o is 1 and rd_valid_o is 0. With rd_req_i high while idle, rd_valid_o is 1 in the same cycle and rd_data_o shows HI when rd_sel_i is 1, or LO when rd_sel_i is 0.
- R9: After reset, HI and LO are zero and busy_o is low.
- R10: HI and LO keep their previous values until an operation completes. A read made in the same cycle as an accepted start returns the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launches an operation when idle |
| op_i | input | 2 | bit1: divide, bit0: unsigned |
| a_i | input | W | First operand (multiplicand or dividend) |
| b_i | input | W | Second operand (multiplier or divisor) |
| rd_req_i | input | 1 | Read request for a result register |
| rd_sel_i | input | 1 | 1 selects HI, 0 selects LO |
| rd_data_o | output | W | Selected result register |
| rd_valid_o | output | 1 | Read served this cycle |
| stall_o | output | 1 | Read must wait, operation in flight |
| busy_o | output | 1 | Operation in progress |

## Verification
The assertions assume that start_i, op_i and the operands are stable around the clock edge. They also assume reset is asserted before the first operation, because the engines' operand registers are meaningful only after a load. The bench meets these assumptions by driving every input on the falling edge, after a reset phase. It runs the block at W=4 and sweeps every operand pair for all four operation codes, with results computed from integer arithmetic.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    typedef enum logic [1:0] {
        MD_IDLE = 2'd0,
        MD_RUN  = 2'd1,
        MD_FIX  = 2'd2
    } md_state_e;

    localparam logic [1:0] OP_MUL_S = 2'b00;
    localparam logic [1:0] OP_MUL_U = 2'b01;
    localparam logic [1:0] OP_DIV_S = 2'b10;
    localparam logic [1:0] OP_DIV_U = 2'b11;

endpackage

// File: rtl/mdu_mul_engine.sv
module mdu_mul_engine #(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [W-1:0]     mcand_i,
    input  logic [W-1:0]     mplier_i,
    output logic [2*W-1:0]   prod_o
);

    typedef struct packed {
        logic [W-1:0]   mcand;
        logic [2*W-1:0] acc;
    } mul_st_t;

    mul_st_t st_d, st_q;
    logic [W:0] part_sum;

    always_comb begin
        st_d     = st_q;
        part_sum = {1'b0, st_q.acc[2*W-1:W]};
        if (load_i) begin
            st_d.mcand = mcand_i;
            st_d.acc   = {{W{1'b0}}, mplier_i};
        end else if (step_i) begin
            if (st_q.acc[0]) begin
                part_sum = {1'b0, st_q.acc[2*W-1:W]} + {1'b0, st_q.mcand};
            end
            st_d.acc = {part_sum, st_q.acc[W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prod_o = st_q.acc;

endmodule

// File: rtl/mdu_div_engine.sv
module mdu_div_engine #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         step_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);

    typedef struct packed {
        logic [W-1:0] dvs;
        logic [W-1:0] rem;
        logic [W-1:0] quo;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [W:0] shifted;
    logic [W:0] trial;

    always_comb begin
        st_d    = st_q;
        shifted = {st_q.rem, st_q.quo[W-1]};
        trial   = shifted - {1'b0, st_q.dvs};
        if (load_i) begin
            st_d.dvs = divisor_i;
            st_d.rem = '0;
            st_d.quo = dividend_i;
        end else if (step_i) begin
            if (!trial[W]) begin
                st_d.rem = trial[W-1:0];
                st_d.quo = {st_q.quo[W-2:0], 1'b1};
            end else begin
                st_d.rem = shifted[W-1:0];
                st_d.quo = {st_q.quo[W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign quo_o = st_q.quo;
    assign rem_o = st_q.rem;

    // R3
    rem_below_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && st_q.dvs != '0) |=> (st_q.rem < st_q.dvs));

endmodule

// File: rtl/mdu_hilo_unit.sv
module mdu_hilo_unit
    import mdu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [1:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         rd_req_i,
    input  logic         rd_sel_i,
    output logic [W-1:0] rd_data_o,
    output logic         rd_valid_o,
    output logic         stall_o,
    output logic         busy_o
);

    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam int BW = $clog2(W + 2) + 1;
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    typedef struct packed {
        md_state_e     state;
        logic [CW-1:0] cnt;
        logic          is_div;
        logic          neg_main;
        logic          neg_aux;
        logic          dvz;
        logic [W-1:0]  dividend;
        logic [W-1:0]  hi;
        logic [W-1:0]  lo;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic           accept;
    logic           signed_op;
    logic [W-1:0]   a_mag, b_mag;
    logic           run_step;
    logic [2*W-1:0] prod_raw, prod_fix;
    logic [W-1:0]   quo_raw, rem_raw;

    function automatic logic [W-1:0] magnitude(input logic [W-1:0] v, input logic sgn);
        return (sgn && v[W-1]) ? (~v + 1'b1) : v;
    endfunction

    assign accept    = start_i && (st_q.state == MD_IDLE);
    assign signed_op = !op_i[0];
    assign a_mag     = magnitude(a_i, signed_op);
    assign b_mag     = magnitude(b_i, signed_op);
    assign run_step  = (st_q.state == MD_RUN);

    mdu_mul_engine #(.W(W)) mul_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept && !op_i[1]),
        .step_i   (run_step && !st_q.is_div),
        .mcand_i  (a_mag),
        .mplier_i (b_mag),
        .prod_o   (prod_raw)
    );

    mdu_div_engine #(.W(W)) div_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept && op_i[1]),
        .step_i     (run_step && st_q.is_div),
        .dividend_i (a_mag),
        .divisor_i  (b_mag),
        .quo_o      (quo_raw),
        .rem_o      (rem_raw)
    );

    assign prod_fix = st_q.neg_main ? (~prod_raw + 1'b1) : prod_raw;

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            MD_IDLE: begin
                if (start_i) begin
                    st_d.state    = MD_RUN;
                    st_d.cnt      = '0;
                    st_d.is_div   = op_i[1];
                    st_d.neg_main = signed_op && (a_i[W-1] ^ b_i[W-1]);
                    st_d.neg_aux  = signed_op && a_i[W-1];
                    st_d.dvz      = (b_i == '0);
                    st_d.dividend = a_i;
                end
            end
            MD_RUN: begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == LAST_STEP) begin
                    st_d.state = MD_FIX;
                end
            end
            MD_FIX: begin
                st_d.state = MD_IDLE;
                if (st_q.is_div) begin
                    if (st_q.dvz) begin
                        st_d.lo = '1;
                        st_d.hi = st_q.dividend;
                    end else begin
                        st_d.lo = st_q.neg_main ? (~quo_raw + 1'b1) : quo_raw;
                        st_d.hi = st_q.neg_aux  ? (~rem_raw + 1'b1) : rem_raw;
                    end
                end else begin
                    st_d.hi = prod_fix[2*W-1:W];
                    st_d.lo = prod_fix[W-1:0];
                end
            end
            default: st_d.state = MD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= MD_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o     = (st_q.state != MD_IDLE);
    assign rd_valid_o = rd_req_i && !busy_o;
    assign stall_o    = rd_req_i && busy_o;
    assign rd_data_o  = rd_sel_i ? st_q.hi : st_q.lo;

    // Length of the current busy stretch, for the window check below.
    logic [BW-1:0] busy_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_run_q <= '0;
        end else if (busy_o) begin
            busy_run_q <= busy_run_q + 1'b1;
        end else begin
            busy_run_q <= '0;
        end
    end

    // R6
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R6
    busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run_q <= BW'(W + 1));

    // R10
    results_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == MD_RUN) |=> ($stable(st_q.hi) && $stable(st_q.lo)));

    // R7
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && st_q.state == MD_RUN && st_q.cnt != LAST_STEP)
            |=> (st_q.state == MD_RUN && st_q.cnt == $past(st_q.cnt) + 1'b1));

endmodule

// File: tb/mdu_hilo_unit_tb_top.sv
module mdu_hilo_unit_tb_top;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [1:0]   op_i = 2'b00;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic         rd_req_i = 1'b0;
    logic         rd_sel_i = 1'b0;
    logic [W-1:0] rd_data_o;
    logic         rd_valid_o;
    logic         stall_o;
    logic         busy_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mdu_hilo_unit #(.W(W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .op_i       (op_i),
        .a_i        (a_i),
        .b_i        (b_i),
        .rd_req_i   (rd_req_i),
        .rd_sel_i   (rd_sel_i),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o),
        .stall_o    (stall_o),
        .busy_o     (busy_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            summary();
        end
    end

    function automatic int sx(input logic [W-1:0] v);
        return v[W-1] ? (int'(v) - (1 << W)) : int'(v);
    endfunction

    task automatic expect_of(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                             output int ehi, output int elo);
        logic [31:0] p;
        int q, r;
        if (!op[1]) begin
            p   = op[0] ? 32'(int'(a) * int'(b)) : 32'(sx(a) * sx(b));
            ehi = int'(p[2*W-1:W]);
            elo = int'(p[W-1:0]);
        end else if (b == '0) begin
            ehi = int'(a);
            elo = (1 << W) - 1;
        end else begin
            if (op[0]) begin
                q = int'(a) / int'(b);
                r = int'(a) % int'(b);
            end else begin
                q = sx(a) / sx(b);
                r = sx(a) % sx(b);
            end
            elo = q & ((1 << W) - 1);
            ehi = r & ((1 << W) - 1);
        end
    endtask

    function automatic string tag_of(input logic [1:0] op, input logic [W-1:0] b);
        if (op[1] && b == '0) return "R5";
        case (op)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic read_both(input string tag, input int ehi, input int elo);
        rd_req_i = 1'b1;
        rd_sel_i = 1'b0;
        #1;
        check({tag, " lo"}, int'(rd_data_o), elo);
        rd_sel_i = 1'b1;
        #1;
        check({tag, " hi"}, int'(rd_data_o), ehi);
        rd_req_i = 1'b0;
    endtask

    task automatic run_op(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        start_i = 1'b1;
        op_i    = op;
        a_i     = a;
        b_i     = b;
        @(negedge clk);
        start_i = 1'b0;
        while (busy_o) @(negedge clk);
    endtask

    initial begin
        int ehi, elo;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        check("R9 busy", int'(busy_o), 0);
        read_both("R9", 0, 0);

        // R6 and R8: busy window length and stall behaviour
        @(negedge clk);
        start_i = 1'b1; op_i = 2'b01; a_i = 4'd3; b_i = 4'd5;
        for (int k = 0; k <= W; k++) begin
            @(negedge clk);
            if (k == 0) start_i = 1'b0;
            check("R6 busy high", int'(busy_o), 1);
            if (k == 1) begin
                rd_req_i = 1'b1;
                #1;
                check("R8 stall", int'(stall_o), 1);
                check("R8 valid low", int'(rd_valid_o), 0);
                rd_req_i = 1'b0;
            end
        end
        @(negedge clk);
        check("R6 busy low", int'(busy_o), 0);
        rd_req_i = 1'b1;
        #1;
        check("R8 valid", int'(rd_valid_o), 1);
        check("R8 no stall", int'(stall_o), 0);
        rd_req_i = 1'b0;
        read_both("R6", 0, 15);

        // R7: second start while busy is ignored
        @(negedge clk);
        start_i = 1'b1; op_i = 2'b00; a_i = 4'd2; b_i = 4'd3;
        @(negedge clk);
        op_i = 2'b11; a_i = 4'd7; b_i = 4'd2;
        @(negedge clk);
        start_i = 1'b0;
        while (busy_o) @(negedge clk);
        read_both("R7", 0, 6);

        // R10: read in the same cycle as an accepted start sees old data
        @(negedge clk);
        start_i = 1'b1; op_i = 2'b11; a_i = 4'd13; b_i = 4'd4;
        rd_req_i = 1'b1; rd_sel_i = 1'b0;
        #1;
        check("R10 old lo", int'(rd_data_o), 6);
        check("R10 valid", int'(rd_valid_o), 1);
        @(negedge clk);
        start_i = 1'b0; rd_req_i = 1'b0;
        while (busy_o) @(negedge clk);
        read_both("R10 new", 1, 3);

        // R1 R2 R3 R4 R5: exhaustive sweep
        for (int op = 0; op < 4; op++) begin
            for (int a = 0; a < (1 << W); a++) begin
                for (int b = 0; b < (1 << W); b++) begin
                    run_op(2'(op), W'(a), W'(b));
                    expect_of(2'(op), W'(a), W'(b), ehi, elo);
                    read_both(tag_of(2'(op), W'(b)), ehi, elo);
                end
            end
        end

        done = 1'b1;
        summary();
    end

endmodule